// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block is the control and status engine of a single DMA channel that processes a chain of descriptors held in memory. Software points the channel at the first descriptor through a next-address register and sets the enable bit. The engine then reads each descriptor over a simple request/valid memory read port and hands the control word and length to a datapath. When the datapath reports completion, the engine writes the length word back with a completion flag and follows the link pointer until it reaches a zero link.

Software watches progress through a status register whose event bits are cleared by writing ones to them. It can extend a finished chain without restarting it. To do that it patches the link of the last descriptor and sets the append bit. The engine then reads that link again and carries on. A single interrupt line summarises completions of descriptors that requested an interrupt, and any error.

Each descriptor is four 32-bit words: link at +0, control at +4, an auxiliary word at +8 that the engine does not read, and the length word at +12.

Top module: `dmach_top`

## Requirements
- R1: After reset the control and status registers read zero, `irq` is low, and no memory read or write request is raised.
- R2: Writing control bit 0 (enable) from 0 to 1 loads the current-descriptor register (offset 0x08) from the next-descriptor register (offset 0x24, read/write) and starts fetching. If that address is zero, nothing is fetched and status bit 11 (end of chain) is set.
- R3: For each descriptor the engine reads the link at +0, the control word at +4 and the length word at +12. It gives the datapath the control word and length bits 23:0 with one `xfer_start` pulse. Descriptors run in link order, and a zero link ends the chain.
- R4: On completion the length word is written back to +12 with bit 31 set and bits 30:0 unchanged. This happens before the next descriptor is read.
- R5: Status bit 13 reads 1 while the channel is working. Bit 12 (end of transfer) sets at each descriptor write-back. Bit 11 sets when the chain ends.
- R6: Writing status clears each of bits 12, 11, 9, 5, 4 and 3 that is written as one. Bits written as zero, and bit 13, are left unchanged.
- R7: A nonzero `xfer_err` code with `xfer_done` sets status bits 3, 4, 5 and 9 for code bits 0, 1, 2 and 3. The engine stops after that descriptor's write-back, leaves bit 11 clear, and does not read the next descriptor.
- R8: Control bit 1 (append), set while the channel is idle and enabled after a chain, makes the engine re-read the link word of the last descriptor. A nonzero link resumes the chain there; a zero link leaves it idle and sets bit 11. The append bit reads back as 0 once it has been taken.
- R9: Clearing enable while the channel is working lets the current descriptor finish and be written back. The engine then stops with busy low and bit 11 set, and the remaining descriptors are not touched.
- R10: `irq` is high while bit 12 is set and a descriptor with control bit 0 (interrupt enable) completed after bit 12 was last cleared, or while any error bit is set. It falls once those bits are cleared.
- R11: Offset 0x28 reads the control word of the current descriptor and offset 0x30 reads its 24-bit length. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_rd_req | output | 1 | Descriptor read request, held until valid |
| mem_rd_addr | output | 32 | Descriptor read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Write-back request, held until acknowledge |
| mem_wr_addr | output | 32 | Write-back address |
| mem_wr_data | output | 32 | Write-back data |
| mem_wr_ack | input | 1 | Write-back accepted |
| xfer_start | output | 1 | One-cycle start pulse to the datapath |
| xfer_ctrl | output | 32 | Control word of the descriptor being run |
| xfer_len | output | 24 | Byte length of the descriptor being run |
| xfer_done | input | 1 | Datapath completion pulse |
| xfer_err | input | 4 | Error code, valid with `xfer_done` |
| irq | output | 1 | Channel interrupt |

## Verification
The chain walk is exercised with four shapes:
- a single descriptor with an interrupt request;
- a three-descriptor chain whose lengths run from 1 to the 24-bit maximum, with upper length-word bits that must come back unchanged;
- an empty chain that starts from a zero address;
- a chain extended by append, once with a patched link and once with a zero link.

Disabling in the middle of a slow transfer separates "finish and stop" from "drop immediately" and from "keep walking": the bench checks that the second descriptor's length word stays unmodified. An error code with two bits set checks the status bit mapping and shows that the chain stops. Clearing single status bits one at a time shows that each one-bit clears only its own flag and that `irq` follows the right flags.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LINK,
    ST_RD_NEXT,
    ST_RD_CTRL,
    ST_RD_BCNT,
    ST_XSTART,
    ST_XWAIT,
    ST_WB
  } walk_st_t;

  // register offsets
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_CUR   = 8'h08;
  localparam logic [7:0] OFS_NEXT  = 8'h24;
  localparam logic [7:0] OFS_DCTRL = 8'h28;
  localparam logic [7:0] OFS_DLEN  = 8'h30;

  // status bit positions
  localparam int STS_BUSY = 13;
  localparam int STS_EOT  = 12;
  localparam int STS_EOC  = 11;
  localparam int ERR_N    = 4;

  // control bit positions
  localparam int CTL_EN  = 0;
  localparam int CTL_APP = 1;

  // descriptor word offsets in bytes
  localparam int DW_LINK = 0;
  localparam int DW_CTRL = 4;
  localparam int DW_BCNT = 12;

  function automatic int err_pos(input int idx);
    case (idx)
      0: return 3;
      1: return 4;
      2: return 5;
      default: return 9;
    endcase
  endfunction

endpackage

// File: rtl/dmach_csr.sv
module dmach_csr
  import dmach_pkg::*;
#(
  parameter int RAW  = 8,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              busy_i,
  input  logic [AW-1:0]     cur_addr_i,
  input  logic [DW-1:0]     desc_ctrl_i,
  input  logic [LENW-1:0]   desc_len_i,
  input  logic              evt_eot_i,
  input  logic              evt_ie_i,
  input  logic              evt_eoc_i,
  input  logic [ERR_N-1:0]  evt_err_i,
  input  logic              go_ack_i,
  input  logic              app_ack_i,
  output logic              go_o,
  output logic              app_o,
  output logic              enable_o,
  output logic [AW-1:0]     next_addr_o,
  output logic              irq_o
);

  localparam logic [RAW-1:0] A_CTRL  = RAW'(OFS_CTRL);
  localparam logic [RAW-1:0] A_STAT  = RAW'(OFS_STAT);
  localparam logic [RAW-1:0] A_CUR   = RAW'(OFS_CUR);
  localparam logic [RAW-1:0] A_NEXT  = RAW'(OFS_NEXT);
  localparam logic [RAW-1:0] A_DCTRL = RAW'(OFS_DCTRL);
  localparam logic [RAW-1:0] A_DLEN  = RAW'(OFS_DLEN);

  logic             en_q, en_d;
  logic             go_q, go_d;
  logic             app_q, app_d;
  logic [AW-1:0]    next_q, next_d;
  logic             eot_q, eot_d;
  logic             eoc_q, eoc_d;
  logic             ie_q, ie_d;
  logic [ERR_N-1:0] err_q, err_d;

  logic ctrl_wr, stat_wr, next_wr;
  logic [DW-1:0] stat_word;

  assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
  assign stat_wr = reg_we && (reg_addr == A_STAT);
  assign next_wr = reg_we && (reg_addr == A_NEXT);

  always_comb begin
    en_d   = en_q;
    go_d   = go_q;
    app_d  = app_q;
    next_d = next_q;
    if (go_ack_i)  go_d  = 1'b0;
    if (app_ack_i) app_d = 1'b0;
    if (ctrl_wr) begin
      en_d = reg_wdata[CTL_EN];
      if (reg_wdata[CTL_EN] && !en_q) go_d = 1'b1;
      if (!reg_wdata[CTL_EN])         go_d = 1'b0;
      if (reg_wdata[CTL_APP])         app_d = 1'b1;
    end
    if (next_wr) next_d = reg_wdata[AW-1:0];
  end

  always_comb begin
    eot_d = eot_q;
    eoc_d = eoc_q;
    ie_d  = ie_q;
    err_d = err_q;
    if (stat_wr) begin
      if (reg_wdata[STS_EOT]) begin
        eot_d = 1'b0;
        ie_d  = 1'b0;
      end
      if (reg_wdata[STS_EOC]) eoc_d = 1'b0;
      for (int i = 0; i < ERR_N; i++)
        if (reg_wdata[err_pos(i)]) err_d[i] = 1'b0;
    end
    if (evt_eot_i) eot_d = 1'b1;
    if (evt_ie_i)  ie_d  = 1'b1;
    if (evt_eoc_i) eoc_d = 1'b1;
    err_d = err_d | evt_err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      go_q   <= 1'b0;
      app_q  <= 1'b0;
      next_q <= '0;
      eot_q  <= 1'b0;
      eoc_q  <= 1'b0;
      ie_q   <= 1'b0;
      err_q  <= '0;
    end else begin
      en_q   <= en_d;
      go_q   <= go_d;
      app_q  <= app_d;
      next_q <= next_d;
      eot_q  <= eot_d;
      eoc_q  <= eoc_d;
      ie_q   <= ie_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[STS_BUSY] = busy_i;
    stat_word[STS_EOT]  = eot_q;
    stat_word[STS_EOC]  = eoc_q;
    for (int i = 0; i < ERR_N; i++) stat_word[err_pos(i)] = err_q[i];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  begin
                 reg_rdata[CTL_EN]  = en_q;
                 reg_rdata[CTL_APP] = app_q;
               end
      A_STAT:  reg_rdata = stat_word;
      A_CUR:   reg_rdata = DW'(cur_addr_i);
      A_NEXT:  reg_rdata = DW'(next_q);
      A_DCTRL: reg_rdata = desc_ctrl_i;
      A_DLEN:  reg_rdata = DW'(desc_len_i);
      default: reg_rdata = '0;
    endcase
  end

  assign go_o        = go_q && en_q;
  assign app_o       = app_q;
  assign enable_o    = en_q;
  assign next_addr_o = next_q;
  assign irq_o       = (eot_q && ie_q) || (|err_q);

  AST_W1C_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[STS_EOC] && !evt_eoc_i) |=> !reg_rdata[STS_EOC] || (reg_addr != A_STAT)); // R6
  AST_APPEND_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (app_ack_i && !(ctrl_wr && reg_wdata[CTL_APP])) |=> !app_o); // R8
  AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_err_i != '0) |=> irq_o); // R10

endmodule

// File: rtl/dmach_walker.sv
module dmach_walker
  import dmach_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              app_i,
  input  logic              enable_i,
  input  logic [AW-1:0]     next_addr_i,
  output logic              go_ack_o,
  output logic              app_ack_o,
  output logic              busy_o,
  output logic [AW-1:0]     cur_addr_o,
  output logic [DW-1:0]     desc_ctrl_o,
  output logic [LENW-1:0]   desc_len_o,
  output logic              evt_eot_o,
  output logic              evt_ie_o,
  output logic              evt_eoc_o,
  output logic [ERR_N-1:0]  evt_err_o,
  output logic              mem_rd_req,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              mem_wr_req,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [DW-1:0]     mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              xfer_start,
  input  logic              xfer_done,
  input  logic [ERR_N-1:0]  xfer_err
);

  localparam logic [AW-1:0] OFF_LINK = AW'(DW_LINK);
  localparam logic [AW-1:0] OFF_CTRL = AW'(DW_CTRL);
  localparam logic [AW-1:0] OFF_BCNT = AW'(DW_BCNT);
  localparam logic [DW-1:0] DONE_BIT = DW'(1) << (DW - 1);

  walk_st_t         st_q, st_d;
  logic [AW-1:0]    cur_q, cur_d;
  logic [AW-1:0]    link_q, link_d;
  logic [DW-1:0]    ctrl_q, ctrl_d;
  logic [DW-1:0]    bcnt_q, bcnt_d;
  logic [ERR_N-1:0] err_q, err_d;

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    link_d = link_q;
    ctrl_d = ctrl_q;
    bcnt_d = bcnt_q;
    err_d  = err_q;
    go_ack_o   = 1'b0;
    app_ack_o  = 1'b0;
    evt_eot_o  = 1'b0;
    evt_ie_o   = 1'b0;
    evt_eoc_o  = 1'b0;
    evt_err_o  = '0;
    mem_rd_req = 1'b0;
    mem_rd_addr = cur_q + OFF_LINK;
    mem_wr_req  = 1'b0;
    mem_wr_addr = cur_q + OFF_BCNT;
    mem_wr_data = bcnt_q | DONE_BIT;
    xfer_start  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (go_i) begin
          go_ack_o = 1'b1;
          cur_d    = next_addr_i;
          if (next_addr_i != '0) st_d = ST_RD_NEXT;
          else                   evt_eoc_o = 1'b1;
        end else if (app_i && enable_i) begin
          app_ack_o = 1'b1;
          if (cur_q == '0) begin
            cur_d = next_addr_i;
            if (next_addr_i != '0) st_d = ST_RD_NEXT;
            else                   evt_eoc_o = 1'b1;
          end else begin
            st_d = ST_LINK;
          end
        end
      end
      ST_LINK: begin
        mem_rd_req = 1'b1;
        if (mem_rd_valid) begin
          if (mem_rd_data[AW-1:0] != '0) begin
            cur_d = mem_rd_data[AW-1:0];
            st_d  = ST_RD_NEXT;
          end else begin
            evt_eoc_o = 1'b1;
            st_d      = ST_IDLE;
          end
        end
      end
      ST_RD_NEXT: begin
        mem_rd_req = 1'b1;
        if (mem_rd_valid) begin
          link_d = mem_rd_data[AW-1:0];
          st_d   = ST_RD_CTRL;
        end
      end
      ST_RD_CTRL: begin
        mem_rd_req  = 1'b1;
        mem_rd_addr = cur_q + OFF_CTRL;
        if (mem_rd_valid) begin
          ctrl_d = mem_rd_data;
          st_d   = ST_RD_BCNT;
        end
      end
      ST_RD_BCNT: begin
        mem_rd_req  = 1'b1;
        mem_rd_addr = cur_q + OFF_BCNT;
        if (mem_rd_valid) begin
          bcnt_d = mem_rd_data;
          st_d   = ST_XSTART;
        end
      end
      ST_XSTART: begin
        xfer_start = 1'b1;
        err_d      = '0;
        st_d       = ST_XWAIT;
      end
      ST_XWAIT: begin
        if (xfer_done) begin
          err_d = xfer_err;
          st_d  = ST_WB;
        end
      end
      ST_WB: begin
        mem_wr_req = 1'b1;
        if (mem_wr_ack) begin
          evt_eot_o = 1'b1;
          evt_ie_o  = ctrl_q[0];
          evt_err_o = err_q;
          if (err_q != '0) begin
            st_d = ST_IDLE;
          end else if (!enable_i || link_q == '0) begin
            evt_eoc_o = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            cur_d = link_q;
            st_d  = ST_RD_NEXT;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      link_q <= '0;
      ctrl_q <= '0;
      bcnt_q <= '0;
      err_q  <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      link_q <= link_d;
      ctrl_q <= ctrl_d;
      bcnt_q <= bcnt_d;
      err_q  <= err_d;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign cur_addr_o  = cur_q;
  assign desc_ctrl_o = ctrl_q;
  assign desc_len_o  = bcnt_q[LENW-1:0];

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr))); // R3
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R3
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_data))); // R4
  AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_ack && !enable_i) |=> !busy_o); // R9

endmodule

// File: rtl/dmach_top.sv
module dmach_top
  import dmach_pkg::*;
#(
  parameter int RAW  = 8,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             mem_rd_req,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [DW-1:0]    mem_rd_data,
  output logic             mem_wr_req,
  output logic [AW-1:0]    mem_wr_addr,
  output logic [DW-1:0]    mem_wr_data,
  input  logic             mem_wr_ack,
  output logic             xfer_start,
  output logic [DW-1:0]    xfer_ctrl,
  output logic [LENW-1:0]  xfer_len,
  input  logic             xfer_done,
  input  logic [3:0]       xfer_err,
  output logic             irq
);

  logic             go, app, enable, go_ack, app_ack, busy;
  logic [AW-1:0]    next_addr, cur_addr;
  logic [DW-1:0]    desc_ctrl;
  logic [LENW-1:0]  desc_len;
  logic             evt_eot, evt_ie, evt_eoc;
  logic [ERR_N-1:0] evt_err;

  dmach_csr #(.RAW(RAW), .AW(AW), .DW(DW), .LENW(LENW)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy_i(busy), .cur_addr_i(cur_addr), .desc_ctrl_i(desc_ctrl), .desc_len_i(desc_len),
    .evt_eot_i(evt_eot), .evt_ie_i(evt_ie), .evt_eoc_i(evt_eoc), .evt_err_i(evt_err),
    .go_ack_i(go_ack), .app_ack_i(app_ack),
    .go_o(go), .app_o(app), .enable_o(enable), .next_addr_o(next_addr), .irq_o(irq)
  );

  dmach_walker #(.AW(AW), .DW(DW), .LENW(LENW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .go_i(go), .app_i(app), .enable_i(enable), .next_addr_i(next_addr),
    .go_ack_o(go_ack), .app_ack_o(app_ack), .busy_o(busy),
    .cur_addr_o(cur_addr), .desc_ctrl_o(desc_ctrl), .desc_len_o(desc_len),
    .evt_eot_o(evt_eot), .evt_ie_o(evt_ie), .evt_eoc_o(evt_eoc), .evt_err_o(evt_err),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .xfer_start(xfer_start), .xfer_done(xfer_done), .xfer_err(xfer_err)
  );

  assign xfer_ctrl = desc_ctrl;
  assign xfer_len  = desc_len;

  AST_XFER_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (!mem_rd_req && !mem_wr_req)); // R3
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_err != '0) |=> !mem_rd_req); // R7

endmodule

// File: tb/dmach_top_tb.sv
module dmach_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_rd_req, mem_wr_req;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        mem_wr_ack = 1'b0;
  logic        xfer_start;
  logic [31:0] xfer_ctrl;
  logic [23:0] xfer_len;
  logic        xfer_done = 1'b0;
  logic [3:0]  xfer_err = '0;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmach_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .xfer_start(xfer_start), .xfer_ctrl(xfer_ctrl), .xfer_len(xfer_len),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .irq(irq)
  );

  // memory and datapath models
  logic [31:0] mem [0:255];
  int          xcnt = 0;
  logic [23:0] xlen_log [0:15];
  logic [31:0] xctl_log [0:15];
  int          dp_delay = 2;
  logic [3:0]  dp_err = '0;
  int          dp_cnt = 0;
  logic        dp_run = 1'b0;

  always @(posedge clk) begin
    if (mem_rd_req && !mem_rd_valid) begin
      mem_rd_valid <= 1'b1;
      mem_rd_data  <= mem[mem_rd_addr[9:2]];
    end else begin
      mem_rd_valid <= 1'b0;
    end
    if (mem_wr_req && !mem_wr_ack) begin
      mem_wr_ack <= 1'b1;
      mem[mem_wr_addr[9:2]] = mem_wr_data;
    end else begin
      mem_wr_ack <= 1'b0;
    end
    xfer_done <= 1'b0;
    xfer_err  <= '0;
    if (xfer_start) begin
      xlen_log[xcnt[3:0]] <= xfer_len;
      xctl_log[xcnt[3:0]] <= xfer_ctrl;
      xcnt   <= xcnt + 1;
      dp_cnt <= dp_delay;
      dp_run <= 1'b1;
    end else if (dp_run) begin
      if (dp_cnt == 0) begin
        xfer_done <= 1'b1;
        xfer_err  <= dp_err;
        dp_run    <= 1'b0;
      end else begin
        dp_cnt <= dp_cnt - 1;
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      rd(8'h04, s);
      if (!s[13]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic put_desc(input int a, input logic [31:0] link, input logic [31:0] ctl,
                          input logic [31:0] bc);
    mem[a/4]     = link;
    mem[a/4 + 1] = ctl;
    mem[a/4 + 2] = 32'hDEAD_0000;
    mem[a/4 + 3] = bc;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d); check("R1 status after reset", d, 32'h0);
    rd(8'h00, d); check("R1 control after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 no memory request", {30'b0, mem_rd_req, mem_wr_req}, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    int base = xcnt;
    put_desc(32'h40, 32'h0, 32'h0000_0001, 32'h0000_0100);
    wr(8'h24, 32'h40);
    rd(8'h24, d); check("R2 next register readback", d, 32'h40);
    wr(8'h00, 32'h1);
    wait_idle();
    check("R3 single transfer count", xcnt - base, 1);
    check("R3 single length", {8'h0, xlen_log[base[3:0]]}, 32'h100);
    check("R3 control to datapath", xctl_log[base[3:0]], 32'h1);
    check("R4 write-back word", mem[32'h4C/4], 32'h8000_0100);
    rd(8'h04, d); check("R5 status after single", d, 32'h0000_1800);
    check("R10 irq after IE descriptor", {31'b0, irq}, 32'h1);
    rd(8'h08, d); check("R2 current address", d, 32'h40);
    rd(8'h28, d); check("R11 control mirror", d, 32'h1);
    rd(8'h30, d); check("R11 length mirror", d, 32'h100);
    rd(8'h14, d); check("R11 unmapped offset", d, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(8'h04, 32'h0000_2000);
    rd(8'h04, d); check("R6 zero/busy write no effect", d, 32'h0000_1800);
    wr(8'h04, 32'h0000_0800);
    rd(8'h04, d); check("R6 clear EOC only", d, 32'h0000_1000);
    check("R10 irq held by EOT", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0000_1000);
    rd(8'h04, d); check("R6 clear EOT", d, 32'h0);
    check("R10 irq falls", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] d;
    int base = xcnt;
    put_desc(32'h80, 32'hA0, 32'h0000_0006, 32'h0000_0001);
    put_desc(32'hA0, 32'hC0, 32'h0000_0008, 32'h0300_0002);
    put_desc(32'hC0, 32'h0,  32'h0000_0000, 32'h00FF_FFFF);
    wr(8'h24, 32'h80);
    wr(8'h00, 32'h1);
    wait_idle();
    check("R3 chain transfer count", xcnt - base, 3);
    check("R3 chain order 0", {8'h0, xlen_log[base[3:0]]}, 32'h1);
    check("R3 chain order 1", {8'h0, xlen_log[4'(base + 1)]}, 32'h2);
    check("R3 chain max length", {8'h0, xlen_log[4'(base + 2)]}, 32'h00FF_FFFF);
    check("R3 chain control 1", xctl_log[4'(base + 1)], 32'h8);
    check("R4 upper bits kept", mem[32'hAC/4], 32'h8300_0002);
    check("R4 last write-back", mem[32'hCC/4], 32'h80FF_FFFF);
    rd(8'h04, d); check("R5 status after chain", d, 32'h0000_1800);
    check("R10 no irq without IE", {31'b0, irq}, 32'h0);
    rd(8'h08, d); check("R3 last descriptor address", d, 32'hC0);
    wr(8'h04, 32'h0000_1800);
  endtask

  task automatic t_append();
    logic [31:0] d;
    int base = xcnt;
    put_desc(32'hE0, 32'h0, 32'h0000_0001, 32'h0000_0005);
    mem[32'hC0/4] = 32'hE0;
    wr(8'h00, 32'h3);
    wait_idle();
    check("R8 append resumes", xcnt - base, 1);
    check("R8 appended length", {8'h0, xlen_log[base[3:0]]}, 32'h5);
    rd(8'h00, d); check("R8 append self-clears", d, 32'h1);
    rd(8'h08, d); check("R8 current after append", d, 32'hE0);
    rd(8'h04, d); check("R5 status after append", d, 32'h0000_1800);
    check("R10 irq after appended IE", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0000_1800);
    base = xcnt;
    wr(8'h00, 32'h3);
    repeat (20) @(negedge clk);
    check("R8 zero link no transfer", xcnt - base, 0);
    rd(8'h00, d); check("R8 append clears on zero link", d, 32'h1);
    rd(8'h04, d); check("R8 idle with EOC", d, 32'h0000_0800);
    wr(8'h04, 32'h0000_0800);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    int base = xcnt;
    put_desc(32'h100, 32'h120, 32'h0, 32'h7);
    put_desc(32'h120, 32'h0,   32'h0, 32'h8);
    dp_delay = 40;
    wr(8'h24, 32'h100);
    wr(8'h00, 32'h1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (xcnt != base) break;
    end
    rd(8'h04, d); check("R5 busy while working", {31'b0, d[13]}, 32'h1);
    wr(8'h00, 32'h0);
    wait_idle();
    dp_delay = 2;
    check("R9 only current finishes", xcnt - base, 1);
    check("R9 current written back", mem[32'h10C/4], 32'h8000_0007);
    check("R9 next untouched", mem[32'h12C/4], 32'h8);
    rd(8'h04, d); check("R9 stopped with EOC", d, 32'h0000_1800);
    wr(8'h04, 32'h0000_1800);
  endtask

  task automatic t_error();
    logic [31:0] d;
    int base = xcnt;
    put_desc(32'h140, 32'h160, 32'h0, 32'h3);
    put_desc(32'h160, 32'h0,   32'h0, 32'h4);
    dp_err = 4'b1001;
    wr(8'h24, 32'h140);
    wr(8'h00, 32'h1);
    wait_idle();
    dp_err = 4'b0000;
    check("R7 chain stops on error", xcnt - base, 1);
    check("R7 next not written", mem[32'h16C/4], 32'h4);
    rd(8'h04, d); check("R7 error bit map", d, 32'h0000_1208);
    check("R10 irq on error", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0000_0208);
    rd(8'h04, d); check("R6 clear error bits", d, 32'h0000_1000);
    check("R10 irq falls after error clear", {31'b0, irq}, 32'h0);
    wr(8'h04, 32'h0000_1000);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_empty();
    logic [31:0] d;
    int base = xcnt;
    wr(8'h24, 32'h0);
    wr(8'h00, 32'h1);
    repeat (8) @(negedge clk);
    check("R2 zero start no transfer", xcnt - base, 0);
    rd(8'h04, d); check("R2 zero start sets EOC", d, 32'h0000_0800);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_w1c();
    t_chain();
    t_append();
    t_disable();
    t_error();
    t_empty();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule